// File: doc/BRIEF.md
# Single-Step Trap and Shadow Context Unit

This unit is the trap-entry and saved-context logic of a small 16-bit processor. It adds a single-step facility to that logic. One bit of the status register turns on a trap that fires on every instruction fetch. When any trap or external interrupt is taken, the unit stores the live program counter, status register and stack pointer into a one-level shadow set. In the same cycle it clears the step bit in the status value it hands back, so the handler runs without trapping again.

The shadow set is always presented on the restore outputs. The core loads those outputs on return-from-interrupt, and that load brings the step bit back when it was set before the trap. A fourth shadow slot holds the handler address for step traps. The read-shadow and write-shadow instructions access every slot by number, so a debugger can set the handler address and edit the saved context. The first fetch after a return never traps, so exactly one instruction runs between two step traps.

Top module: `step_trap_unit`

## Requirements
- R1: With status bit 3 (step bit) set, a fetch that does not directly follow a return raises `trap_taken` in the same cycle, with `trap_is_step` high and `isr_addr` equal to shadow slot 3. With `fetch` low, no trap is raised.
- R2: A step trap wins over a concurrent interrupt request, and `isr_addr` is then slot 3. An interrupt is never taken while the step bit is set.
- R3: With the step bit clear, `irq_req` together with `fetch` raises `trap_taken` with `trap_is_step` low and `isr_addr` equal to `irq_vec`.
- R4: In the cycle after a trap, `ret_pc`, `ret_sr` and `ret_sp` equal the `cur_pc`, `cur_sr` and `cur_sp` of the trap cycle. These include the step bit as it stood at the trap.
- R5: `sr_out` equals `cur_sr` with bit 3 cleared in a trap cycle, and equals `cur_sr` unchanged otherwise.
- R6: A fetch in the cycle after an `rti` cycle raises no step trap. The next fetch after that one traps again if the step bit is set.
- R7: `sh_rdata` is combinational. Slot number 0 returns the saved PC, 1 the saved SR, 2 the saved SP and 3 the step handler address. Numbers 4 to 7 return zero.
- R8: `sh_wr` writes `sh_wdata` into the selected slot at the clock edge. Writes to numbers 4 to 7 change nothing. A trap in the same cycle overrides a write to slots 0 to 2.
- R9: Synchronous reset clears all shadow slots and the return flag.
- R10: The shadow set has one level. A second trap overwrites the context saved by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| fetch | input | 1 | an instruction fetch happens this cycle |
| cur_pc | input | 16 | live program counter |
| cur_sr | input | 16 | live status register, bit 3 is the step bit |
| cur_sp | input | 16 | live stack pointer |
| irq_req | input | 1 | external interrupt request, held until taken |
| irq_vec | input | 16 | handler address of the external interrupt |
| rti | input | 1 | return-from-interrupt executes this cycle |
| sh_sel | input | 3 | shadow slot number for read and write |
| sh_wr | input | 1 | write-shadow strobe |
| sh_wdata | input | 16 | write-shadow data |
| sh_rdata | output | 16 | read-shadow data |
| trap_taken | output | 1 | a trap or interrupt is entered at this fetch |
| trap_is_step | output | 1 | the trap taken is the step trap |
| isr_addr | output | 16 | handler address to jump to |
| sr_out | output | 16 | status value for the core to load |
| ret_pc | output | 16 | saved PC to restore on return |
| ret_sr | output | 16 | saved SR to restore on return |
| ret_sp | output | 16 | saved SP to restore on return |

## Verification
Trap decision, `isr_addr`, `sr_out` and `sh_rdata` are due in the same cycle as their inputs. The bench drives inputs on the falling edge and samples these outputs one nanosecond later, before the rising edge. Saved context, handler address writes and the return flag take effect at the next rising edge. Their effects are therefore compared on the following cycle's sample, against a bench model that updates only after that sample.

// File: rtl/step_trap_pkg.sv
package step_trap_pkg;
    localparam int WORD_W   = 16;
    localparam int SEL_W    = 3;
    localparam int STEP_BIT = 3;
    localparam int SLOTS    = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;

    localparam sel_t SLOT_PC  = sel_t'(0);
    localparam sel_t SLOT_SR  = sel_t'(1);
    localparam sel_t SLOT_SP  = sel_t'(2);
    localparam sel_t SLOT_VEC = sel_t'(3);

    typedef struct packed {
        word_t pc;
        word_t sr;
        word_t sp;
    } ctx_t;

    function automatic word_t drop_step(input word_t sr);
        word_t r;
        r = sr;
        r[STEP_BIT] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import step_trap_pkg::*;
(
    input  logic  fetch,
    input  logic  step_on,
    input  logic  after_ret,
    input  logic  irq_req,
    input  word_t irq_vec,
    input  word_t step_vec,
    output logic  take,
    output logic  is_step,
    output word_t target
);
    logic step_hit;
    logic irq_hit;

    always_comb begin
        step_hit = fetch && step_on && !after_ret;
        irq_hit  = fetch && irq_req && !step_on;
        take     = step_hit || irq_hit;
        is_step  = step_hit;
        target   = step_hit ? step_vec : irq_vec;
    end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
    import step_trap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  save,
    input  ctx_t  ctx_in,
    input  logic  wr,
    input  sel_t  sel,
    input  word_t wdata,
    output ctx_t  ctx_q,
    output word_t step_vec,
    output word_t rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q    <= '0;
            step_vec <= '0;
        end else begin
            if (save) begin
                ctx_q <= ctx_in;
            end else if (wr) begin
                if (sel == SLOT_PC) ctx_q.pc <= wdata;
                if (sel == SLOT_SR) ctx_q.sr <= wdata;
                if (sel == SLOT_SP) ctx_q.sp <= wdata;
            end
            if (wr && sel == SLOT_VEC) step_vec <= wdata;
        end
    end

    always_comb begin
        case (sel)
            SLOT_PC:  rdata = ctx_q.pc;
            SLOT_SR:  rdata = ctx_q.sr;
            SLOT_SP:  rdata = ctx_q.sp;
            SLOT_VEC: rdata = step_vec;
            default:  rdata = '0;
        endcase
    end

    assert_save_ctx_R4: assert property (@(posedge clk) disable iff (rst)
        save |=> (ctx_q.pc == $past(ctx_in.pc)) && (ctx_q.sr == $past(ctx_in.sr))
                 && (ctx_q.sp == $past(ctx_in.sp)));

    assert_unused_slot_R8: assert property (@(posedge clk) disable iff (rst)
        (wr && !save && int'(sel) >= SLOTS) |=> $stable(ctx_q) && $stable(step_vec));

    assert_unused_read_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(sel) >= SLOTS) |-> rdata == '0);
endmodule

// File: rtl/step_trap_unit.sv
module step_trap_unit
    import step_trap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch,
    input  logic [15:0] cur_pc,
    input  logic [15:0] cur_sr,
    input  logic [15:0] cur_sp,
    input  logic        irq_req,
    input  logic [15:0] irq_vec,
    input  logic        rti,
    input  logic [2:0]  sh_sel,
    input  logic        sh_wr,
    input  logic [15:0] sh_wdata,
    output logic [15:0] sh_rdata,
    output logic        trap_taken,
    output logic        trap_is_step,
    output logic [15:0] isr_addr,
    output logic [15:0] sr_out,
    output logic [15:0] ret_pc,
    output logic [15:0] ret_sr,
    output logic [15:0] ret_sp
);
    logic  after_ret;
    ctx_t  live_ctx;
    ctx_t  saved_ctx;
    word_t step_vec;

    // set by a return, cleared by the first fetch that follows it
    always_ff @(posedge clk) begin
        if (rst)        after_ret <= 1'b0;
        else if (rti)   after_ret <= 1'b1;
        else if (fetch) after_ret <= 1'b0;
    end

    assign live_ctx = '{pc: cur_pc, sr: cur_sr, sp: cur_sp};

    trap_arbiter u_arb (
        .fetch     (fetch),
        .step_on   (cur_sr[STEP_BIT]),
        .after_ret (after_ret),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .step_vec  (step_vec),
        .take      (trap_taken),
        .is_step   (trap_is_step),
        .target    (isr_addr)
    );

    shadow_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .save     (trap_taken),
        .ctx_in   (live_ctx),
        .wr       (sh_wr),
        .sel      (sh_sel),
        .wdata    (sh_wdata),
        .ctx_q    (saved_ctx),
        .step_vec (step_vec),
        .rdata    (sh_rdata)
    );

    assign sr_out = trap_taken ? drop_step(cur_sr) : cur_sr;
    assign ret_pc = saved_ctx.pc;
    assign ret_sr = saved_ctx.sr;
    assign ret_sp = saved_ctx.sp;

    assert_step_fires_R1: assert property (@(posedge clk) disable iff (rst)
        (fetch && cur_sr[STEP_BIT] && !after_ret) |-> trap_taken && trap_is_step
                                                     && isr_addr == step_vec);

    assert_no_irq_when_step_R2: assert property (@(posedge clk) disable iff (rst)
        cur_sr[STEP_BIT] |-> !(trap_taken && !trap_is_step));

    assert_step_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> !sr_out[STEP_BIT]);

    assert_skip_after_ret_R6: assert property (@(posedge clk) disable iff (rst)
        rti |=> !trap_is_step);

    assert_no_trap_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !fetch |-> !trap_taken);
endmodule

// File: tb/step_trap_unit_bench.sv
module step_trap_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        fetch, irq_req, rti, sh_wr;
    logic [15:0] cur_pc, cur_sr, cur_sp, irq_vec, sh_wdata;
    logic [2:0]  sh_sel;
    logic [15:0] sh_rdata, isr_addr, sr_out, ret_pc, ret_sr, ret_sp;
    logic        trap_taken, trap_is_step;

    int n_vec = 0;
    int n_bad = 0;

    // bench model of the saved state
    logic [15:0] m_pc, m_sr, m_sp, m_vec;
    logic        m_skip;

    always #4 clk = ~clk;

    step_trap_unit u_step_trap_unit (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive one cycle, check combinational results and the state from earlier edges
    task automatic cyc(input logic f, input logic irq, input logic [15:0] sr,
                       input logic r, input logic w, input logic [2:0] sel,
                       input logic [15:0] d);
        logic step, itk, tk;
        logic [15:0] rd;
        @(negedge clk);
        fetch = f; irq_req = irq; cur_sr = sr; rti = r; sh_wr = w; sh_sel = sel;
        sh_wdata = d;
        cur_pc = d ^ 16'h1357; cur_sp = d + 16'h0420; irq_vec = d ^ 16'hA0A0;
        #1;
        step = f && sr[3] && !m_skip;
        itk  = f && irq && !sr[3];
        tk   = step || itk;
        case (sel)
            3'd0: rd = m_pc;
            3'd1: rd = m_sr;
            3'd2: rd = m_sp;
            3'd3: rd = m_vec;
            default: rd = 16'h0000;
        endcase
        chk("R1/R2/R3/R6 trap_taken", {15'd0, trap_taken}, {15'd0, tk});
        chk("R1/R2/R6 trap_is_step", {15'd0, trap_is_step}, {15'd0, step});
        if (tk) chk("R1/R2/R3 isr_addr", isr_addr, step ? m_vec : irq_vec);
        chk("R5 sr_out", sr_out, tk ? (sr & 16'hFFF7) : sr);
        chk("R7 sh_rdata", sh_rdata, rd);
        chk("R4/R8/R10 ret_pc", ret_pc, m_pc);
        chk("R4/R8/R10 ret_sr", ret_sr, m_sr);
        chk("R4/R8/R10 ret_sp", ret_sp, m_sp);
        if (tk) begin
            m_pc = cur_pc; m_sr = sr; m_sp = cur_sp;
        end else if (w) begin
            if (sel == 3'd0) m_pc = d;
            if (sel == 3'd1) m_sr = d;
            if (sel == 3'd2) m_sp = d;
        end
        if (w && sel == 3'd3) m_vec = d;
        if (r) m_skip = 1'b1;
        else if (f) m_skip = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        fetch = 0; irq_req = 0; rti = 0; sh_wr = 0; sh_sel = 0;
        cur_pc = 0; cur_sr = 0; cur_sp = 0; irq_vec = 0; sh_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_pc = 0; m_sr = 0; m_sp = 0; m_vec = 0; m_skip = 0;
        // R9: reset state seen through every slot
        for (int s = 0; s < 8; s++) begin
            @(negedge clk); sh_sel = 3'(s); #1;
            chk("R9 reset slot", sh_rdata, 16'h0000);
        end
        chk("R9 reset ret_pc", ret_pc, 16'h0000);
        chk("R9 reset trap", {15'd0, trap_taken}, 16'h0000);

        // R1: program step handler, then step through a few fetches
        cyc(0, 0, 16'h0000, 0, 1, 3'd3, 16'hC000);
        cyc(1, 0, 16'h0008, 0, 0, 3'd3, 16'h0100);
        cyc(1, 1, 16'h0008, 0, 0, 3'd0, 16'h0101); // R2: step wins, R10 overwrite
        // R6: return, then one free fetch, then trap again
        cyc(0, 0, 16'h0000, 1, 0, 3'd1, 16'h0102);
        cyc(1, 0, 16'h0008, 0, 0, 3'd1, 16'h0103);
        cyc(1, 0, 16'h0008, 0, 0, 3'd2, 16'h0104);
        // R3: interrupt with step bit clear
        cyc(1, 1, 16'h0011, 0, 0, 3'd0, 16'h0200);
        // R8: trap overrides a write, unused slot write ignored
        cyc(1, 1, 16'h0000, 0, 1, 3'd0, 16'h0300);
        cyc(0, 0, 16'h0000, 0, 1, 3'd6, 16'hFFFF);
        cyc(0, 0, 16'h0000, 0, 0, 3'd0, 16'h0301);

        // near-exhaustive sweep over all control combinations
        for (int i = 0; i < 1024; i++) begin
            logic [15:0] d;
            d = 16'(i * 40503 + 77);
            cyc(i[0], i[1], {d[15:4], i[2], d[2:0]}, i[3] & i[9], i[4], i[7:5], d);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule